// File: doc/BRIEF.md
# Grouped ADC Conversion Sequencer

This block orders sample and convert operations for an ADC front end. Its analog inputs form four groups, A to D, each with its own channel select. A start pulse loads the configuration and runs one of five patterns. One pattern converts a single channel. Two patterns are sequential and sample each channel on holding unit 0 just before its conversion. Two patterns are paired: they strobe holding units 0 and 1 in the same cycle and then convert the two held values one after the other.

The converter itself sits outside the block. For each step the block drives the multiplexer selects, the hold strobes, a convert-start pulse and the number of the unit to convert. It then waits for the converter's done pulse. Each result goes into a small FIFO tagged with its group. An interrupt pulse marks finished sequences. In single-shot operation the block stops after one sequence. In continuous operation it repeats the sequence until asked to halt, and the interrupt can be thinned to every second or fourth sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `scan_en`=0, a start runs one sample on unit 0 and one conversion. `mode` is the group (0=A, 1=B, 2=C, 3=D) and the channel is that group's select.
- R2: With `scan_en`=1 and `mode`=00, the block converts group A and then group B. Each conversion is preceded by a one-cycle `sh0_strobe`, and `conv_start` follows in the next cycle.
- R3: With `scan_en`=1 and `mode`=01, the block converts groups A, B, C and D in that order, each sampled on unit 0.
- R4: With `scan_en`=1 and `mode`=10, `sh0_strobe` and `sh1_strobe` rise in the same cycle, with `mux0_sel` on A and `mux1_sel` on B. Unit 0 is converted first (A), then unit 1 (B). `sh1_strobe` is never raised in any other mode.
- R5: With `scan_en`=1 and `mode`=11, the R4 pattern for A/B is followed by a paired sample of C (unit 0) and D (unit 1), converted C then D.
- R6: `mux0_sel`/`mux1_sel` carry the group in bits [3:2] and the channel in bits [1:0]. `grp_sel` packs group g's select at bits [2g+1:2g]. Each stored result carries its group on `rd_group`.
- R7: In single-shot operation (`cont_en`=0), `irq` pulses for one cycle exactly once per sequence, after the last result is stored.
- R8: In continuous operation (`cont_en`=1), the sequence repeats until `halt`, and the sequence in progress completes. `irq_rate` 00 or 11 pulses `irq` after every sequence, 01 after every 2nd and 10 after every 4th, counted from the start.
- R9: The result FIFO holds 4 entries and shows its oldest entry on `rd_data`/`rd_group`. `rd_en` removes that entry. `buf_empty` is 1 after reset and 0 once a result is stored. A result arriving while the FIFO is full is discarded.
- R10: The configuration and selects are captured when a start is accepted. Changes to them while `busy`, and further start pulses while `busy`, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted when idle |
| halt | input | 1 | Ends continuous operation after the current sequence |
| scan_en | input | 1 | 0: single channel, 1: multi-group pattern |
| mode | input | 2 | Group (single) or pattern (multi-group) |
| cont_en | input | 1 | 0: single-shot, 1: continuous |
| irq_rate | input | 2 | Interrupt thinning in continuous operation |
| grp_sel | input | 8 | Per-group channel selects, A in the low bits |
| mux0_sel | output | 4 | Group and channel routed to holding unit 0 |
| mux1_sel | output | 4 | Group and channel routed to holding unit 1 |
| sh0_strobe | output | 1 | Sample strobe for unit 0 |
| sh1_strobe | output | 1 | Sample strobe for unit 1 |
| conv_start | output | 1 | Convert-start pulse |
| conv_unit | output | 1 | Holding unit to convert |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result, valid with conv_done |
| busy | output | 1 | Sequence in progress |
| irq | output | 1 | Interrupt pulse |
| rd_en | input | 1 | Removes the oldest FIFO entry |
| rd_data | output | 10 | Oldest result |
| rd_group | output | 2 | Group of the oldest result |
| buf_empty | output | 1 | FIFO holds no result |

## Verification
The properties assume the converter answers each `conv_start` with exactly one single-cycle `conv_done`, and never while no conversion is pending. They also assume `start` and `halt` are pulses. The bench stub answers every convert-start once after a random delay of one to four cycles. Its result is computed from the value it latched on that unit's hold strobe, so a wrong strobe or select shows up as a wrong code. In continuous runs the bench drains the FIFO as results appear, which keeps it from filling. Only the directed full-FIFO case lets results pile up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int GRP_W = 2;

   typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV, ST_WAIT} seq_state_t;

   typedef struct packed {
      logic       scan;
      logic [1:0] mode;
      logic       cont;
      logic [1:0] rate;
   } seq_cfg_t;

   function automatic logic [2:0] conv_total(input logic scan, input logic [1:0] mode);
      if (!scan) return 3'd1;
      return mode[0] ? 3'd4 : 3'd2;
   endfunction

   function automatic logic paired(input logic scan, input logic [1:0] mode);
      return scan & mode[1];
   endfunction
endpackage

// File: rtl/adc_seq_plan.sv
module adc_seq_plan
   import adc_seq_pkg::*;
(
   input  logic             scan,
   input  logic [1:0]       mode,
   input  logic [1:0]       idx,
   output logic [GRP_W-1:0] cgrp,
   output logic [GRP_W-1:0] pgrp,
   output logic             unit,
   output logic             last,
   output logic             nxt_samp
);
   logic pair;
   assign pair     = paired(scan, mode);
   assign cgrp     = scan ? idx : mode;
   assign pgrp     = {idx[1], 1'b1};
   assign unit     = pair & idx[0];
   assign last     = ({1'b0, idx} == conv_total(scan, mode) - 3'd1);
   assign nxt_samp = !pair | idx[0];
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
   parameter int CNT_W = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       seq_end,
   input  logic       cont,
   input  logic [1:0] rate,
   output logic       irq
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("adc_seq_irq: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nx, mask;
   logic             hit;

   always_comb begin
      case (rate)
         2'b01:   mask = CNT_W'(1);
         2'b10:   mask = CNT_W'(3);
         default: mask = '0;
      endcase
   end

   assign cnt_nx = cnt_q + CNT_W'(1);
   assign hit    = ((cnt_nx & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= seq_end & (!cont | hit);
         if (clr)          cnt_q <= '0;
         else if (seq_end) cnt_q <= cnt_nx;
      end
   end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int W     = 12,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_seq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [AW:0]   cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (AW+1)'(DEPTH));
   assign do_push = push & !full;
   assign do_pop  = pop & !empty;
   assign dout    = mem[rd_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 mem[i] <= '0;
         else if (do_push && wr_q == AW'(i))          mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + AW'(1);
         if (do_pop)  rd_q <= rd_q + AW'(1);
         cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int CH_W       = 2,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  halt,
   input  logic                  scan_en,
   input  logic [1:0]            mode,
   input  logic                  cont_en,
   input  logic [1:0]            irq_rate,
   input  logic [4*CH_W-1:0]     grp_sel,
   output logic [GRP_W+CH_W-1:0] mux0_sel,
   output logic [GRP_W+CH_W-1:0] mux1_sel,
   output logic                  sh0_strobe,
   output logic                  sh1_strobe,
   output logic                  conv_start,
   output logic                  conv_unit,
   input  logic                  conv_done,
   input  logic [DATA_W-1:0]     conv_data,
   output logic                  busy,
   output logic                  irq,
   input  logic                  rd_en,
   output logic [DATA_W-1:0]     rd_data,
   output logic [GRP_W-1:0]      rd_group,
   output logic                  buf_empty
);
   localparam int N_GRP  = 1 << GRP_W;
   localparam int ENT_W  = GRP_W + DATA_W;

   if (DATA_W < 1 || CH_W < 1) begin : g_bad_width
      $error("adc_seq_ctrl: DATA_W and CH_W must be positive");
   end

   seq_state_t       state_q;
   seq_cfg_t         cfg_q;
   logic [1:0]       idx_q;
   logic             stop_q;
   logic [CH_W-1:0]  sel_q [N_GRP];
   logic [GRP_W-1:0] cgrp, pgrp;
   logic             last, nxt_samp, load, push, seq_end, fifo_full;
   logic [ENT_W-1:0] head;

   assign load    = (state_q == ST_IDLE) && start;
   assign push    = (state_q == ST_WAIT) && conv_done;
   assign seq_end = push && last;

   for (genvar g = 0; g < N_GRP; g++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sel_q[g] <= '0;
         else if (load) sel_q[g] <= grp_sel[g*CH_W +: CH_W];
      end
   end

   adc_seq_plan i_plan (
      .scan     (cfg_q.scan),
      .mode     (cfg_q.mode),
      .idx      (idx_q),
      .cgrp     (cgrp),
      .pgrp     (pgrp),
      .unit     (conv_unit),
      .last     (last),
      .nxt_samp (nxt_samp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         idx_q   <= '0;
         stop_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               cfg_q   <= '{scan: scan_en, mode: mode, cont: cont_en, rate: irq_rate};
               idx_q   <= '0;
               stop_q  <= 1'b0;
               state_q <= ST_SAMP;
            end
            ST_SAMP: state_q <= ST_CONV;
            ST_CONV: state_q <= ST_WAIT;
            ST_WAIT: if (conv_done) begin
               if (last) begin
                  idx_q   <= '0;
                  state_q <= (cfg_q.cont && !stop_q && !halt) ? ST_SAMP : ST_IDLE;
               end else begin
                  idx_q   <= idx_q + 2'd1;
                  state_q <= nxt_samp ? ST_SAMP : ST_CONV;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (halt && state_q != ST_IDLE) stop_q <= 1'b1;
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign sh0_strobe = (state_q == ST_SAMP);
   assign sh1_strobe = (state_q == ST_SAMP) && paired(cfg_q.scan, cfg_q.mode);
   assign conv_start = (state_q == ST_CONV);
   assign mux0_sel   = {cgrp, sel_q[cgrp]};
   assign mux1_sel   = {pgrp, sel_q[pgrp]};

   adc_seq_irq #(.CNT_W(2)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (load),
      .seq_end (seq_end),
      .cont    (cfg_q.cont),
      .rate    (cfg_q.rate),
      .irq     (irq)
   );

   adc_seq_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({cgrp, conv_data}),
      .pop   (rd_en),
      .dout  (head),
      .empty (buf_empty),
      .full  (fifo_full)
   );

   assign rd_data  = head[DATA_W-1:0];
   assign rd_group = head[ENT_W-1 -: GRP_W];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             sh0_strobe,
   input logic             sh1_strobe,
   input logic             conv_start,
   input logic [SEL_W-1:0] mux0_sel,
   input logic [SEL_W-1:0] mux1_sel,
   input logic             irq,
   input seq_cfg_t         cfg_q
);
   // R2: a sample strobe is followed by a convert-start in the next cycle
   p_samp_then_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sh0_strobe |=> conv_start);

   // R2: convert-start is a single-cycle pulse
   p_conv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R4: unit 1 is strobed only together with unit 0, on the next group
   p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sh1_strobe |-> (sh0_strobe &&
         mux1_sel[SEL_W-1 -: GRP_W] == mux0_sel[SEL_W-1 -: GRP_W] + GRP_W'(1)));

   // R4: unit 1 is strobed only in the paired patterns
   p_pair_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sh1_strobe |-> (cfg_q.scan && cfg_q.mode[1]));

   // R7: an interrupt follows a cycle in which a sequence was running
   p_irq_after_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(busy));

   // R10: captured configuration holds while a sequence runs
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.SEL_W(adc_seq_pkg::GRP_W + CH_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .sh0_strobe (sh0_strobe),
   .sh1_strobe (sh1_strobe),
   .conv_start (conv_start),
   .mux0_sel   (mux0_sel),
   .mux1_sel   (mux1_sel),
   .irq        (irq),
   .cfg_q      (cfg_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, halt = 1'b0, scan_en = 1'b0, cont_en = 1'b0;
   logic [1:0] mode = '0, irq_rate = '0;
   logic [7:0] grp_sel = '0;
   logic [3:0] mux0_sel, mux1_sel;
   logic       sh0_strobe, sh1_strobe, conv_start, conv_unit, busy, irq, buf_empty;
   logic       conv_done = 1'b0, rd_en = 1'b0;
   logic [9:0] conv_data = '0, rd_data;
   logic [1:0] rd_group;

   int nchk = 0, nerr = 0, cycles = 0;
   int irq_cnt = 0, popped = 0, pend = 0;
   bit drain = 1'b1;
   logic [3:0] salt = '0;
   logic [3:0] cap [2];
   int exp_q[$];
   string cur_tag = "R1";

   always #2 clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .scan_en(scan_en),
      .mode(mode), .cont_en(cont_en), .irq_rate(irq_rate), .grp_sel(grp_sel),
      .mux0_sel(mux0_sel), .mux1_sel(mux1_sel), .sh0_strobe(sh0_strobe),
      .sh1_strobe(sh1_strobe), .conv_start(conv_start), .conv_unit(conv_unit),
      .conv_done(conv_done), .conv_data(conv_data), .busy(busy), .irq(irq),
      .rd_en(rd_en), .rd_data(rd_data), .rd_group(rd_group), .buf_empty(buf_empty));

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic logic [9:0] code(input logic [3:0] s, input logic [3:0] gc);
      return {s, gc, 2'b01};
   endfunction

   function automatic int n_of(input bit scan, input logic [1:0] md);
      if (!scan) return 1;
      return md[0] ? 4 : 2;
   endfunction

   function automatic int entry(input bit scan, input logic [1:0] md, input logic [7:0] sl, input int k, input logic [3:0] s);
      logic [1:0] g;
      g = scan ? 2'(k) : md;
      return (int'(g) << 10) | int'(code(s, {g, sl[2*g +: 2]}));
   endfunction

   function automatic int rate_n(input logic [1:0] rt);
      return (rt == 2'b01) ? 2 : (rt == 2'b10) ? 4 : 1;
   endfunction

   function automatic string tag_of(input bit scan, input logic [1:0] md);
      if (!scan) return "R1";
      case (md)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   // converter stub, result drain, pulse counting
   initial begin
      cap[0] = '0; cap[1] = '0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         rd_en = 1'b0;
         if (rst_n) begin
            if (irq) irq_cnt++;
            if (sh1_strobe && !sh0_strobe) chk(1'b0, "R4", "unit 1 strobed alone", 1, 0);
            if (sh0_strobe) cap[0] = mux0_sel;
            if (sh1_strobe) cap[1] = mux1_sel;
            if (pend > 0) begin
               pend--;
               if (pend == 0) begin
                  conv_done = 1'b1;
                  conv_data = code(salt, cap[conv_unit]);
               end
            end
            if (conv_start) pend = 1 + int'($urandom % 4);
            if (drain && !buf_empty) begin
               if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected result", {rd_group, rd_data}, -1);
               else begin
                  int e;
                  e = exp_q.pop_front();
                  chk({rd_group, rd_data} == 12'(e), cur_tag, "result/group (R6)", {rd_group, rd_data}, e);
               end
               rd_en = 1'b1;
               popped++;
            end
         end
      end
   end

   task automatic wait_idle(input string tag);
      int n = 0;
      @(negedge clk);
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(!busy, tag, "sequence end", busy, 0);
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic run_shot(input bit scan, input logic [1:0] md, input logic [7:0] sl, input bit disturb);
      int n;
      salt++;
      n = n_of(scan, md);
      cur_tag = tag_of(scan, md);
      for (int k = 0; k < n; k++) exp_q.push_back(entry(scan, md, sl, k, salt));
      irq_cnt = 0; popped = 0;
      @(negedge clk);
      scan_en = scan; mode = md; grp_sel = sl; cont_en = 1'b0;
      pulse_start();
      if (disturb) begin
         // R10: changes and a second start while busy have no effect
         scan_en = ~scan; mode = 2'($urandom); grp_sel = 8'($urandom); cont_en = 1'b1;
         pulse_start();
      end
      wait_idle(cur_tag);
      chk(popped == n, cur_tag, disturb ? "conversion count (R10)" : "conversion count", popped, n);
      chk(irq_cnt == 1, "R7", "single-shot irq pulses", irq_cnt, 1);
      exp_q.delete();
   endtask

   task automatic run_loop(input bit scan, input logic [1:0] md, input logic [1:0] rt, input logic [7:0] sl, input int nseq);
      int n, tgt, w;
      salt++;
      n = n_of(scan, md);
      cur_tag = tag_of(scan, md);
      for (int r = 0; r < 12; r++)
         for (int k = 0; k < n; k++) exp_q.push_back(entry(scan, md, sl, k, salt));
      irq_cnt = 0; popped = 0;
      @(negedge clk);
      scan_en = scan; mode = md; grp_sel = sl; cont_en = 1'b1; irq_rate = rt;
      pulse_start();
      tgt = nseq * n; w = 0;
      while (popped < tgt && w < 5000) begin @(negedge clk); w++; end
      halt = 1'b1; @(negedge clk); halt = 1'b0;
      wait_idle("R8");
      chk(popped % n == 0, "R8", "whole sequences after halt", popped % n, 0);
      chk(popped >= tgt, "R8", "sequences before halt", popped, tgt);
      chk(irq_cnt == (popped / n) / rate_n(rt), "R8", "irq thinning", irq_cnt, (popped / n) / rate_n(rt));
      exp_q.delete();
      cont_en = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            chk(1'b0, "R1", "watchdog expired", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      chk(buf_empty == 1'b1, "R9", "empty after reset", buf_empty, 1);
      chk(busy == 1'b0, "R10", "idle after reset", busy, 0);
      chk(irq == 1'b0, "R7", "irq after reset", irq, 0);
      chk(sh0_strobe == 1'b0 && conv_start == 1'b0, "R2", "no activity in reset", conv_start, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: buffer-empty drops after the first store, full FIFO discards
      drain = 1'b0;
      salt++;
      cur_tag = "R9";
      for (int k = 0; k < 4; k++) exp_q.push_back(entry(1'b1, 2'b01, 8'hE4, k, salt));
      popped = 0;
      scan_en = 1'b1; mode = 2'b01; grp_sel = 8'hE4; cont_en = 1'b0;
      pulse_start();
      wait_idle("R9");
      chk(buf_empty == 1'b0, "R9", "buffer-empty after store", buf_empty, 0);
      salt++;
      pulse_start();
      wait_idle("R9");
      drain = 1'b1;
      repeat (12) @(negedge clk);
      chk(popped == 4, "R9", "entries kept when full", popped, 4);
      chk(exp_q.size() == 0, "R9", "oldest entries retained", exp_q.size(), 0);
      exp_q.delete();

      // directed: every pattern, single channel on each group
      for (int g = 0; g < 4; g++) run_shot(1'b0, 2'(g), 8'h1B, 1'b0);
      for (int m = 0; m < 4; m++) run_shot(1'b1, 2'(m), 8'h6C, 1'b0);
      run_shot(1'b1, 2'b11, 8'hD2, 1'b1);
      run_shot(1'b0, 2'b10, 8'h39, 1'b1);
      run_loop(1'b1, 2'b10, 2'b01, 8'hA5, 4);
      run_loop(1'b0, 2'b01, 2'b10, 8'h5A, 8);
      run_loop(1'b1, 2'b11, 2'b11, 8'h0F, 3);

      // constrained random
      for (int t = 0; t < 24; t++) begin
         bit sc;
         logic [1:0] md;
         logic [7:0] sl;
         sc = 1'($urandom);
         md = 2'($urandom);
         sl = 8'($urandom);
         if ($urandom % 4 == 0) run_loop(sc, md, 2'($urandom), sl, 1 + int'($urandom % 5));
         else run_shot(sc, md, sl, 1'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule